// File: doc/BRIEF.md
# Configurable Timer with Prescaler

This block is a small timer/counter peripheral on a byte-wide register bus. It counts either every cycle of the block clock or selected edges of an external input, and can run as an 8-bit or a 16-bit counter. An optional prescaler sits between the clock events and the counter. It divides by a power of two from 2 to 256. The prescaler cannot be read or written. Software controls it only through the control register, and a write to the count clears it.

When the counter wraps, a sticky overflow flag is set. The interrupt request output is that flag gated by an enable bit. Software polls or services the flag and then clears it by a write. A sleep input freezes all counting while it is high. In 16-bit mode, accesses to the two count bytes go through a holding byte, so that software always sees a consistent 16-bit value.

Register map (2-bit address): 0 = control, 1 = count low byte, 2 = count high byte, 3 = status. Status bit 0 is the overflow flag and bit 1 is the interrupt enable. Control bits: 7 run, 6 eight-bit mode, 5 source (1 = external input), 4 external edge (0 = rising, 1 = falling), 3 prescaler bypass, 2:0 ratio select.

Top module: `tick_timer`

## Requirements
- R1: After reset, control, count (both bytes) and status all read 0x00, and the interrupt request is low.
- R2: When control bit 3 is 0, the counter advances once every 2^(sel+1) clock events, where sel is control bits 2:0 (0 gives 1:2, 7 gives 1:256).
- R3: When control bit 3 is 1, the counter advances on every clock event.
- R4: A write to address 1 or 2 clears the prescaler. The control register reads back unchanged after such a write.
- R5: Control bit 3 may be changed while the timer runs. Events before the change follow the old setting and events after it follow the new one.
- R6: In 8-bit mode (control bit 6 = 1), only the low byte counts. A wrap from 0xFF to 0x00 sets the flag, and the high byte keeps its value. A high-byte write lands directly.
- R7: In 16-bit mode, the count wraps from 0xFFFF to 0x0000, and that wrap sets the flag.
- R8: The flag stays set until a status write with bit 0 = 0. A status write with bit 0 = 1 leaves the flag unchanged.
- R9: The interrupt request is high exactly when both the flag and the enable (status bit 1) are set.
- R10: While sleep is high, no clock events are counted, so neither the count nor the flag changes.
- R11: With control bit 5 = 1, events come from the external input after a two-stage synchronizer. Rising edges count when bit 4 = 0, and falling edges count when bit 4 = 1.
- R12: In 16-bit mode, a high-byte write is held and only reaches the counter with the next low-byte write. A low-byte read captures the high byte, which a later high-byte read returns.
- R13: With control bit 7 = 0, the count does not change except by bus writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the internal count source |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Register address |
| busWr | input | 1 | Write strobe, one cycle per write |
| busRd | input | 1 | Read strobe, one cycle per read |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for the addressed register |
| extClk | input | 1 | Asynchronous external count input |
| sleep | input | 1 | Freezes counting while high |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets four kinds of error. A prescaler that survives a count write would add a stray extra increment, so it runs a partial prescale, rewrites the count and checks that nothing advances. It switches the bypass mid-run, where a design that applied the new setting at the wrong time would be off by a count or more. It drives 8-bit and 16-bit wraps and checks the flag and the untouched high byte; a design that wraps at the wrong width shows a wrong high byte or a missing flag. Held high-byte writes, sleep, and both external edge polarities are checked as well, since a stuck edge select or a leaky sleep gate produces a visibly wrong count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned BYTE_W = 8;

  // control register bit positions (software decodes these)
  localparam int unsigned CTL_RUN    = 7;
  localparam int unsigned CTL_MODE8  = 6;
  localparam int unsigned CTL_SRC    = 5;
  localparam int unsigned CTL_EDGE   = 4;
  localparam int unsigned CTL_BYPASS = 3;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_LOW  = 2'd1,
    ADDR_HIGH = 2'd2,
    ADDR_STAT = 2'd3
  } tmrAddr_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              tick;
    logic              loadLow;
    logic              loadHigh;
    logic              mode8;
    logic [BYTE_W-1:0] lowData;
    logic [BYTE_W-1:0] highData;
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int unsigned PRE_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          busAddr,
  input  logic                busWr,
  input  logic                busRd,
  input  logic [BYTE_W-1:0]   busWdata,
  output logic [BYTE_W-1:0]   busRdata,
  input  logic                extClk,
  input  logic                sleep,
  input  logic [2*BYTE_W-1:0] count,
  input  logic                ovf,
  output tmrStrobe_t          strobe,
  output logic [BYTE_W-1:0]   ctrlReg,
  output logic                flag,
  output logic                irq
);
  localparam int unsigned SEL_W = $clog2(PRE_W);

  logic [BYTE_W-1:0]      ctrlQ, holdQ;
  logic                   flagQ, ienQ;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   extPrevQ;
  logic [PRE_W-1:0]       preQ, preMask;
  logic                   wrCtrl, wrLow, wrHigh, wrStat, rdLow;
  logic                   syncOut, extEdge, clkEvent, preDone, tick;
  logic [SEL_W-1:0]       sel;

  assign wrCtrl = busWr && (busAddr == ADDR_CTRL);
  assign wrLow  = busWr && (busAddr == ADDR_LOW);
  assign wrHigh = busWr && (busAddr == ADDR_HIGH);
  assign wrStat = busWr && (busAddr == ADDR_STAT);
  assign rdLow  = busRd && (busAddr == ADDR_LOW);

  // external input synchronizer and edge detect
  assign syncOut = syncQ[SYNC_STAGES-1];
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ    <= '0;
      extPrevQ <= 1'b0;
    end else begin
      syncQ    <= {syncQ[SYNC_STAGES-2:0], extClk};
      extPrevQ <= syncOut;
    end
  end
  assign extEdge = ctrlQ[CTL_EDGE] ? (extPrevQ && !syncOut) : (!extPrevQ && syncOut);

  assign clkEvent = ctrlQ[CTL_RUN] && !sleep && (ctrlQ[CTL_SRC] ? extEdge : 1'b1);

  // prescaler: terminal when the low sel+1 bits are all ones
  assign sel = ctrlQ[SEL_W-1:0];
  always_comb begin
    for (int i = 0; i < PRE_W; i++) preMask[i] = (i <= int'(sel));
  end
  assign preDone = ((preQ & preMask) == preMask);
  assign tick    = clkEvent && (ctrlQ[CTL_BYPASS] || preDone);

  always_ff @(posedge clk) begin
    if (!rstN)                                 preQ <= '0;
    else if (wrLow || wrHigh)                  preQ <= '0;
    else if (clkEvent && !ctrlQ[CTL_BYPASS])   preQ <= preDone ? '0 : preQ + 1'b1;
  end

  // registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
      holdQ <= '0;
      flagQ <= 1'b0;
      ienQ  <= 1'b0;
    end else begin
      if (wrCtrl) ctrlQ <= busWdata;
      if (wrHigh)     holdQ <= busWdata;
      else if (rdLow) holdQ <= count[2*BYTE_W-1:BYTE_W];
      if (ovf)                        flagQ <= 1'b1;
      else if (wrStat && !busWdata[0]) flagQ <= 1'b0;
      if (wrStat) ienQ <= busWdata[1];
    end
  end

  always_comb begin
    strobe.tick     = tick;
    strobe.loadLow  = wrLow;
    strobe.loadHigh = wrHigh;
    strobe.mode8    = ctrlQ[CTL_MODE8];
    strobe.lowData  = busWdata;
    strobe.highData = ctrlQ[CTL_MODE8] ? busWdata : holdQ;
  end

  always_comb begin
    unique case (busAddr)
      ADDR_CTRL: busRdata = ctrlQ;
      ADDR_LOW:  busRdata = count[BYTE_W-1:0];
      ADDR_HIGH: busRdata = ctrlQ[CTL_MODE8] ? count[2*BYTE_W-1:BYTE_W] : holdQ;
      default:   busRdata = {{(BYTE_W-2){1'b0}}, ienQ, flagQ};
    endcase
  end

  assign ctrlReg = ctrlQ;
  assign flag    = flagQ;
  assign irq     = flagQ && ienQ;
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  tmrStrobe_t          strobe,
  output logic [2*BYTE_W-1:0] count,
  output logic                ovf
);
  localparam int unsigned CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0] countQ;
  logic             busLoad;

  assign busLoad = strobe.loadLow || (strobe.loadHigh && strobe.mode8);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (strobe.loadLow) begin
      if (strobe.mode8) countQ[BYTE_W-1:0] <= strobe.lowData;
      else              countQ <= {strobe.highData, strobe.lowData};
    end else if (strobe.loadHigh && strobe.mode8) begin
      countQ[CNT_W-1:BYTE_W] <= strobe.highData;
    end else if (strobe.tick) begin
      if (strobe.mode8) countQ[BYTE_W-1:0] <= countQ[BYTE_W-1:0] + 1'b1;
      else              countQ <= countQ + 1'b1;
    end
  end

  assign ovf   = strobe.tick && !busLoad &&
                 (strobe.mode8 ? (&countQ[BYTE_W-1:0]) : (&countQ));
  assign count = countQ;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tmr_pkg::*;
#(
  parameter int unsigned PRE_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] busAddr,
  input  logic       busWr,
  input  logic       busRd,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  input  logic       extClk,
  input  logic       sleep,
  output logic       irq
);
  tmrStrobe_t          strobe;
  logic [2*BYTE_W-1:0] count;
  logic                ovf, flag;
  logic [BYTE_W-1:0]   ctrlReg;

  tmr_ctrl #(.PRE_W(PRE_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .extClk(extClk), .sleep(sleep),
    .count(count), .ovf(ovf), .strobe(strobe), .ctrlReg(ctrlReg),
    .flag(flag), .irq(irq)
  );

  tmr_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .count(count), .ovf(ovf)
  );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic [1:0]          busAddr,
  input logic                busWr,
  input logic [BYTE_W-1:0]   busWdata,
  input logic                sleep,
  input logic                irq,
  input logic [2*BYTE_W-1:0] count,
  input logic [BYTE_W-1:0]   ctrlReg,
  input logic                flag,
  input tmrStrobe_t          strobe
);
  logic cntWrite, flagClr;
  assign cntWrite = busWr && (busAddr == ADDR_LOW || busAddr == ADDR_HIGH);
  assign flagClr  = busWr && (busAddr == ADDR_STAT) && !busWdata[0];

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (flag && !flagClr) |=> flag);

  a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> flag);

  a_r10_sleep_freeze: assert property (@(posedge clk) disable iff (!rstN)
    (sleep && !cntWrite) |=> $stable(count));

  a_r13_off_freeze: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlReg[CTL_RUN] && !cntWrite) |=> $stable(count));

  a_r7_wrap16_flag: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && !strobe.mode8 && !strobe.loadLow && count == 16'hFFFF)
      |=> (flag && count == 16'h0000));

  a_r6_high_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.mode8 && !(busWr && busAddr == ADDR_HIGH))
      |=> $stable(count[2*BYTE_W-1:BYTE_W]));
endmodule

bind tick_timer tmr_checker u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
  .busWdata(busWdata), .sleep(sleep), .irq(irq), .count(count),
  .ctrlReg(ctrlReg), .flag(flag), .strobe(strobe)
);

// File: tb/tb_tick_timer.sv
`timescale 1ns/100ps
module tb_tick_timer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [7:0] busWdata = 8'd0;
  logic [7:0] busRdata;
  logic       extClk = 1'b0;
  logic       sleep = 1'b0;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tick_timer dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .extClk(extClk), .sleep(sleep),
    .irq(irq)
  );

  // all tasks start and end at a falling edge
  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic readCount(output logic [15:0] v);
    logic [7:0] lo, hi;
    busRead(2'd1, lo);
    busRead(2'd2, hi);
    v = {hi, lo};
  endtask

  task automatic setCount(input logic [15:0] v);
    busWrite(2'd2, v[15:8]);
    busWrite(2'd1, v[7:0]);
  endtask

  // the timer runs for k+1 clock events
  task automatic runFor(input logic [7:0] cfg, input int k);
    busWrite(2'd0, cfg | 8'h80);
    repeat (k) @(negedge clk);
    busWrite(2'd0, cfg & 8'h7F);
  endtask

  function automatic int expTicks(input int events, input bit bypass, input int sel);
    return bypass ? events : (events >> (sel + 1));
  endfunction

  task automatic extPulses(input int n);
    for (int i = 0; i < n; i++) begin
      extClk = ~extClk;
      repeat (4) @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000 * 8) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  rd;
    logic [15:0] cv;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    busRead(2'd0, rd); check("R1 ctrl", rd, 8'h00);
    readCount(cv);     check("R1 count", cv, 16'h0000);
    busRead(2'd3, rd); check("R1 status", rd, 8'h00);
    check("R1 irq", irq, 0);

    // R13 run bit clear: no counting
    repeat (10) @(negedge clk);
    readCount(cv); check("R13 stopped", cv, 16'h0000);

    // R2 ratio 1:8, 20 events -> 2 ticks
    setCount(16'h0100);
    runFor(8'h02, 19);
    readCount(cv); check("R2 ratio 1:8", cv, 16'h0102);

    // R4 prescaler cleared by count write: 5 events, rewrite, 5 events -> 0 ticks
    setCount(16'h0000);
    runFor(8'h02, 4);
    setCount(16'h0010);
    busRead(2'd0, rd); check("R4 ctrl unchanged", rd, 8'h02);
    runFor(8'h02, 4);
    readCount(cv); check("R4 prescaler cleared", cv, 16'h0010);

    // R5 switch to bypass while running: 6 events at 1:2 then 4 bypassed -> 3+4
    setCount(16'h0000);
    busWrite(2'd0, 8'h80);
    repeat (5) @(negedge clk);
    busWrite(2'd0, 8'h88);
    repeat (3) @(negedge clk);
    busWrite(2'd0, 8'h08);
    readCount(cv); check("R5 on-the-fly switch", cv, 16'd7);

    // R7 16-bit wrap, R8 sticky flag, R9 irq
    busWrite(2'd3, 8'h02);
    setCount(16'hFFFE);
    runFor(8'h08, 2);
    readCount(cv); check("R7 wrap value", cv, 16'h0001);
    busRead(2'd3, rd); check("R7 flag set", rd, 8'h03);
    check("R9 irq high", irq, 1);
    repeat (20) @(negedge clk);
    busWrite(2'd3, 8'h03);
    busRead(2'd3, rd); check("R8 flag kept by write of 1", rd[0], 1);
    busWrite(2'd3, 8'h01);
    check("R9 irq masked", irq, 0);
    busRead(2'd3, rd); check("R8 flag kept with mask", rd[0], 1);
    busWrite(2'd3, 8'h00);
    busRead(2'd3, rd); check("R8 flag cleared", rd, 8'h00);

    // R6 8-bit mode wrap keeps high byte
    busWrite(2'd0, 8'h48);
    setCount(16'h5AFD);
    runFor(8'h48, 4);
    readCount(cv); check("R6 8-bit wrap", cv, 16'h5A02);
    busRead(2'd3, rd); check("R6 flag", rd[0], 1);
    busWrite(2'd3, 8'h00);

    // R12 held high byte
    busWrite(2'd0, 8'h08);
    setCount(16'h1234);
    busWrite(2'd2, 8'h56);
    readCount(cv); check("R12 high not committed", cv, 16'h1234);
    busWrite(2'd2, 8'h56);
    busWrite(2'd1, 8'h78);
    readCount(cv); check("R12 commit on low write", cv, 16'h5678);

    // R10 sleep freezes count and flag
    setCount(16'hFFFF);
    sleep = 1'b1;
    runFor(8'h08, 12);
    sleep = 1'b0;
    readCount(cv); check("R10 sleep count", cv, 16'hFFFF);
    busRead(2'd3, rd); check("R10 sleep flag", rd[0], 0);

    // R11 external rising edges: 3 rising, 2 falling
    extClk = 1'b0;
    repeat (6) @(negedge clk);
    setCount(16'h0000);
    busWrite(2'd0, 8'hA8);
    extPulses(5);
    repeat (6) @(negedge clk);
    busWrite(2'd0, 8'h28);
    readCount(cv); check("R11 rising edges", cv, 16'd3);
    // falling: 2 falling, 1 rising
    setCount(16'h0000);
    busWrite(2'd0, 8'hB8);
    extPulses(3);
    repeat (6) @(negedge clk);
    busWrite(2'd0, 8'h38);
    readCount(cv); check("R11 falling edges", cv, 16'd2);

    // random trials: R2 R3 R6 R7
    for (int t = 0; t < 40; t++) begin
      bit          mode8, bypass, wrapExp;
      int          sel, k, ticks, lo;
      logic [15:0] start, exp16;
      logic [7:0]  cfg, st;
      mode8  = 1'($urandom % 2);
      bypass = 1'($urandom % 2);
      sel    = int'($urandom % 8);
      k      = int'($urandom % 300) + 1;
      start  = 16'($urandom);
      if (t % 2 == 0) start = mode8 ? {start[15:8], 8'hF8} : 16'hFFF0 | start[3:0];
      cfg = {1'b0, mode8, 2'b00, bypass, 3'(sel)};
      busWrite(2'd0, cfg);
      setCount(start);
      busWrite(2'd3, 8'h02);
      runFor(cfg, k);
      ticks = expTicks(k + 1, bypass, sel);
      if (mode8) begin
        lo      = int'(start[7:0]) + ticks;
        exp16   = {start[15:8], 8'(lo)};
        wrapExp = lo > 255;
      end else begin
        exp16   = 16'(int'(start) + ticks);
        wrapExp = (int'(start) + ticks) > 65535;
      end
      readCount(cv);
      check(mode8 ? "R6 random count" : (bypass ? "R3 random count" : "R2 random count"),
            cv, exp16);
      busRead(2'd3, st);
      check(mode8 ? "R6 random flag" : "R7 random flag", st[0], wrapExp);
      check("R9 random irq", irq, wrapExp);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule